// File: doc/BRIEF.md
# Dual-Clock Processor Mailbox

This block lets two processors with unrelated clocks exchange bytes. Each direction has its own one-byte mailbox. The host writes a byte that the sub processor collects, and the sub processor writes a byte that the host collects. Each mailbox keeps a full flag. A write fills the mailbox and the read at the far side empties it. Each flag lives as a pair of toggle bits, one per clock domain. Each toggle is seen by the other domain only through a two-flop synchroniser.

Both processors reach the block through plain address-decoded strobes. A strobe held for one cycle is one access. Each side has a data address and a status address. The bus has no back-pressure: an access is always taken in the cycle it is presented. Flow control works through the full flags and the DMA requests instead. A write into a mailbox that is still full is dropped and sets that side's sticky overrun bit. On the sub side a DMA controller can empty the inbound mailbox and fill the outbound one. Each of the two jobs has its own request and acknowledge pair.

Top module: `cpu_mailbox`

## Requirements
- R1: After reset both full flags, both overrun bits and both DMA requests are 0, and both status reads return 8'h00.
- R2: A host write to its data address (8'h40) loads the host-to-sub mailbox when it is empty. A sub read of its data address (8'h10) returns that byte and empties the mailbox.
- R3: A sub write to 8'h10 loads the sub-to-host mailbox when it is empty. A host read of 8'h40 returns that byte and empties the mailbox.
- R4: The status address is the data address plus one (host 8'h41, sub 8'h11). Status bit 0 is the host-to-sub full flag, bit 1 is the sub-to-host full flag, bit 2 is the overrun bit of that side's own writes, and bits 7:3 read 0. Any address outside a side's pair reads 8'h00 and has no effect.
- R5: The writing side sees its mailbox full after the write edge. The reading side sees it full after the third edge of its own clock, counting the write edge. After a read, the reading side sees the mailbox empty after that read edge, and the writing side sees it empty after the third edge.
- R6: `s_drq_rx` is high while the sub side sees the host-to-sub mailbox full. A `s_dack_rx` pulse puts the byte on `s_rdata` in that cycle and empties the mailbox.
- R7: `s_drq_tx` is high when `s_tx_en` is 1 and the sub side sees the sub-to-host mailbox empty. A `s_dack_tx` pulse loads `s_wdata` into it.
- R8: A write to a mailbox that its writer sees full leaves the stored byte unchanged and sets that writer's overrun bit. The bit stays set until reset.
- R9: A read of an empty mailbox returns the stored byte and leaves both flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Host clock |
| hrst_n | input | 1 | Host-domain reset, active low |
| h_addr | input | 8 | Host address |
| h_rd | input | 1 | Host read strobe, one cycle per access |
| h_wr | input | 1 | Host write strobe, one cycle per access |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data, combinational |
| sclk | input | 1 | Sub clock |
| srst_n | input | 1 | Sub-domain reset, active low |
| s_addr | input | 8 | Sub address |
| s_rd | input | 1 | Sub read strobe |
| s_wr | input | 1 | Sub write strobe |
| s_wdata | input | 8 | Sub write data, also used by DMA transmit |
| s_rdata | output | 8 | Sub read data, also used by DMA receive |
| s_tx_en | input | 1 | Enables the DMA transmit request |
| s_drq_rx | output | 1 | DMA request: inbound byte waiting |
| s_dack_rx | input | 1 | DMA acknowledge, takes the inbound byte |
| s_drq_tx | output | 1 | DMA request: outbound mailbox free |
| s_dack_tx | input | 1 | DMA acknowledge, writes the outbound byte |

## Verification
Read data and status are combinational, so a read is sampled one time unit after its strobe is driven and before the clock edge. A flag change on the writer's own side is due one edge after the access. A change on the far side is due three edges after it. The bench drives both clock ports from one clock so that these counts are exact. The latency test samples the far side after one, two and three edges to show that the change lands on the third. Every table step is followed by three idle edges, so each later status read sees the crossing complete.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int MBX_DW   = 8;
  localparam int MBX_AW   = 8;
  localparam int MBX_SYNC = 2;

  localparam int ST_H2S_FULL = 0;
  localparam int ST_S2H_FULL = 1;
  localparam int ST_OVERRUN  = 2;

  typedef logic [MBX_DW-1:0] mbx_byte_t;

  function automatic mbx_byte_t mk_status(logic h2s_full, logic s2h_full, logic ovr);
    mbx_byte_t s;
    s = '0;
    s[ST_H2S_FULL] = h2s_full;
    s[ST_S2H_FULL] = s2h_full;
    s[ST_OVERRUN]  = ovr;
    return s;
  endfunction
endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mbx_decode.sv
module mbx_decode #(
  parameter int AW   = 8,
  parameter int BASE = 0
) (
  input  logic [AW-1:0] addr,
  input  logic          rd,
  input  logic          wr,
  output logic          data_rd,
  output logic          data_wr,
  output logic          stat_rd
);
  localparam logic [AW-1:0] BASE_V = AW'(BASE);
  logic hit;

  assign hit     = (addr[AW-1:1] == BASE_V[AW-1:1]);
  assign data_rd = hit && !addr[0] && rd;
  assign data_wr = hit && !addr[0] && wr;
  assign stat_rd = hit &&  addr[0] && rd;
endmodule

// File: rtl/mbx_chan.sv
module mbx_chan
  import mbx_pkg::*;
#(
  parameter int SYNC = MBX_SYNC
) (
  input  logic      wclk,
  input  logic      wrst_n,
  input  logic      wr_req,
  input  mbx_byte_t wdata,
  output logic      w_full,
  output logic      w_ovr,
  input  logic      rclk,
  input  logic      rrst_n,
  input  logic      rd_req,
  output mbx_byte_t rdata,
  output logic      r_full
);
  mbx_byte_t store_q;
  logic      wtgl_q, rtgl_q, ovr_q;
  logic      wtgl_in_r, rtgl_in_w;

  // writer domain: store, toggle, sticky overrun
  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      store_q <= '0;
      wtgl_q  <= 1'b0;
      ovr_q   <= 1'b0;
    end else if (wr_req) begin
      if (w_full) begin
        ovr_q <= 1'b1;
      end else begin
        store_q <= wdata;
        wtgl_q  <= ~wtgl_q;
      end
    end
  end

  // reader domain: consume toggle
  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n)               rtgl_q <= 1'b0;
    else if (rd_req && r_full) rtgl_q <= ~rtgl_q;
  end

  mbx_sync #(.STAGES(SYNC)) u_w2r (.clk(rclk), .rst_n(rrst_n), .d(wtgl_q), .q(wtgl_in_r));
  mbx_sync #(.STAGES(SYNC)) u_r2w (.clk(wclk), .rst_n(wrst_n), .d(rtgl_q), .q(rtgl_in_w));

  assign w_full = wtgl_q ^ rtgl_in_w;
  assign r_full = wtgl_in_r ^ rtgl_q;
  assign w_ovr  = ovr_q;
  assign rdata  = store_q;

  assert_wfull_set_R5: assert property (@(posedge wclk) disable iff (!wrst_n)
    (wr_req && !w_full) |=> w_full);
  assert_hold_when_full_R8: assert property (@(posedge wclk) disable iff (!wrst_n)
    w_full |=> $stable(store_q));
  assert_ovr_sticky_R8: assert property (@(posedge wclk) disable iff (!wrst_n)
    w_ovr |=> w_ovr);
  assert_rfull_clear_R2: assert property (@(posedge rclk) disable iff (!rrst_n)
    (rd_req && r_full) |=> !r_full);
  assert_empty_read_R9: assert property (@(posedge rclk) disable iff (!rrst_n)
    (rd_req && !r_full) |=> $stable(rtgl_q));
endmodule

// File: rtl/cpu_mailbox.sv
module cpu_mailbox
  import mbx_pkg::*;
#(
  parameter int AW        = MBX_AW,
  parameter int HOST_BASE = 'h40,
  parameter int SUB_BASE  = 'h10,
  parameter int SYNC      = MBX_SYNC
) (
  input  logic          hclk,
  input  logic          hrst_n,
  input  logic [AW-1:0] h_addr,
  input  logic          h_rd,
  input  logic          h_wr,
  input  mbx_byte_t     h_wdata,
  output mbx_byte_t     h_rdata,
  input  logic          sclk,
  input  logic          srst_n,
  input  logic [AW-1:0] s_addr,
  input  logic          s_rd,
  input  logic          s_wr,
  input  mbx_byte_t     s_wdata,
  output mbx_byte_t     s_rdata,
  input  logic          s_tx_en,
  output logic          s_drq_rx,
  input  logic          s_dack_rx,
  output logic          s_drq_tx,
  input  logic          s_dack_tx
);
  logic h_data_rd, h_data_wr, h_stat_rd;
  logic s_data_rd, s_data_wr, s_stat_rd;
  logic h2s_wfull, h2s_rfull, h_ovr;
  logic s2h_wfull, s2h_rfull, s_ovr;
  mbx_byte_t h2s_byte, s2h_byte;
  logic s_take, s_give;

  mbx_decode #(.AW(AW), .BASE(HOST_BASE)) u_hdec (
    .addr(h_addr), .rd(h_rd), .wr(h_wr),
    .data_rd(h_data_rd), .data_wr(h_data_wr), .stat_rd(h_stat_rd));

  mbx_decode #(.AW(AW), .BASE(SUB_BASE)) u_sdec (
    .addr(s_addr), .rd(s_rd), .wr(s_wr),
    .data_rd(s_data_rd), .data_wr(s_data_wr), .stat_rd(s_stat_rd));

  assign s_take = s_data_rd || s_dack_rx;
  assign s_give = s_data_wr || s_dack_tx;

  mbx_chan #(.SYNC(SYNC)) u_h2s (
    .wclk(hclk), .wrst_n(hrst_n), .wr_req(h_data_wr), .wdata(h_wdata),
    .w_full(h2s_wfull), .w_ovr(h_ovr),
    .rclk(sclk), .rrst_n(srst_n), .rd_req(s_take),
    .rdata(h2s_byte), .r_full(h2s_rfull));

  mbx_chan #(.SYNC(SYNC)) u_s2h (
    .wclk(sclk), .wrst_n(srst_n), .wr_req(s_give), .wdata(s_wdata),
    .w_full(s2h_wfull), .w_ovr(s_ovr),
    .rclk(hclk), .rrst_n(hrst_n), .rd_req(h_data_rd),
    .rdata(s2h_byte), .r_full(s2h_rfull));

  always_comb begin
    h_rdata = '0;
    if (h_data_rd)      h_rdata = s2h_byte;
    else if (h_stat_rd) h_rdata = mk_status(h2s_wfull, s2h_rfull, h_ovr);
  end

  always_comb begin
    s_rdata = '0;
    if (s_take)         s_rdata = h2s_byte;
    else if (s_stat_rd) s_rdata = mk_status(h2s_rfull, s2h_wfull, s_ovr);
  end

  assign s_drq_rx = h2s_rfull;
  assign s_drq_tx = s_tx_en && !s2h_wfull;

  assert_drq_rx_drop_R6: assert property (@(posedge sclk) disable iff (!srst_n)
    (s_dack_rx && s_drq_rx && !s_data_rd) |=> !s_drq_rx);
  assert_drq_tx_drop_R7: assert property (@(posedge sclk) disable iff (!srst_n)
    (s_dack_tx && s_drq_tx) |=> !s_drq_tx);
  assert_no_tx_req_when_off_R7: assert property (@(posedge sclk) disable iff (!srst_n)
    (!s_tx_en) |-> !s_drq_tx);
  always_comb begin
    if (hrst_n) assert_status_top_zero_R4: assert (h_stat_rd ? (h_rdata[7:3] == 5'd0) : 1'b1);
  end
endmodule

// File: tb/cpu_mailbox_tb.sv
module cpu_mailbox_tb;
  localparam int OP_IDLE = 0, OP_HWR = 1, OP_HRD = 2, OP_HST = 3,
                 OP_SWR = 4, OP_SRD = 5, OP_SST = 6;
  localparam int NV = 26;
  // {req, op, wdata, expected}
  localparam logic [27:0] VEC [NV] = '{
    {4'd1, 8'(OP_HST), 8'h00, 8'h00},  // R1 host status clear
    {4'd1, 8'(OP_SST), 8'h00, 8'h00},  // R1 sub status clear
    {4'd2, 8'(OP_HWR), 8'hA5, 8'h00},  // R2 host fills mailbox
    {4'd5, 8'(OP_HST), 8'h00, 8'h01},  // R5 writer sees full
    {4'd5, 8'(OP_SST), 8'h00, 8'h01},  // R5 reader sees full
    {4'd2, 8'(OP_SRD), 8'h00, 8'hA5},  // R2 sub takes byte
    {4'd2, 8'(OP_SST), 8'h00, 8'h00},  // R2 emptied
    {4'd5, 8'(OP_HST), 8'h00, 8'h00},  // R5 host sees empty
    {4'd3, 8'(OP_SWR), 8'h3C, 8'h00},  // R3 sub fills
    {4'd4, 8'(OP_SST), 8'h00, 8'h02},  // R4 bit1
    {4'd4, 8'(OP_HST), 8'h00, 8'h02},  // R4 bit1 host view
    {4'd3, 8'(OP_HRD), 8'h00, 8'h3C},  // R3 host takes byte
    {4'd3, 8'(OP_HST), 8'h00, 8'h00},  // R3 emptied
    {4'd9, 8'(OP_HRD), 8'h00, 8'h3C},  // R9 empty read returns stored byte
    {4'd9, 8'(OP_SST), 8'h00, 8'h00},  // R9 flags unchanged
    {4'd8, 8'(OP_HWR), 8'h11, 8'h00},
    {4'd8, 8'(OP_HWR), 8'h22, 8'h00},  // R8 overrun write
    {4'd8, 8'(OP_HST), 8'h00, 8'h05},  // R8 overrun bit set
    {4'd8, 8'(OP_SRD), 8'h00, 8'h11},  // R8 byte kept
    {4'd8, 8'(OP_HST), 8'h00, 8'h04},  // R8 sticky
    {4'd4, 8'(OP_SST), 8'h00, 8'h00},  // R4 bit2 is per side
    {4'd8, 8'(OP_SWR), 8'h77, 8'h00},
    {4'd8, 8'(OP_SWR), 8'h88, 8'h00},  // R8 sub overrun
    {4'd8, 8'(OP_SST), 8'h00, 8'h06},
    {4'd8, 8'(OP_HRD), 8'h00, 8'h77},
    {4'd8, 8'(OP_SST), 8'h00, 8'h04}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic [7:0] h_addr, h_wdata, h_rdata, s_addr, s_wdata, s_rdata;
  logic h_rd, h_wr, s_rd, s_wr, s_tx_en, s_drq_rx, s_dack_rx, s_drq_tx, s_dack_tx;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  cpu_mailbox u_dut (
    .hclk(clk), .hrst_n(rst_n), .h_addr(h_addr), .h_rd(h_rd), .h_wr(h_wr),
    .h_wdata(h_wdata), .h_rdata(h_rdata),
    .sclk(clk), .srst_n(rst_n), .s_addr(s_addr), .s_rd(s_rd), .s_wr(s_wr),
    .s_wdata(s_wdata), .s_rdata(s_rdata), .s_tx_en(s_tx_en),
    .s_drq_rx(s_drq_rx), .s_dack_rx(s_dack_rx), .s_drq_tx(s_drq_tx), .s_dack_tx(s_dack_tx));

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic idle_bus();
    h_rd = 0; h_wr = 0; s_rd = 0; s_wr = 0; s_dack_rx = 0; s_dack_tx = 0;
  endtask

  task automatic edges(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; idle_bus(); s_tx_en = 0;
    h_addr = 0; s_addr = 0; h_wdata = 0; s_wdata = 0;
    edges(3);
    rst_n = 1;
    edges(1);
  endtask

  // drives at a falling edge, samples combinational read data 1 time unit later
  task automatic do_op(int op, logic [7:0] wd, output logic [7:0] rd);
    case (op)
      OP_HWR: begin h_addr = 8'h40; h_wdata = wd; h_wr = 1; end
      OP_HRD: begin h_addr = 8'h40; h_rd = 1; end
      OP_HST: begin h_addr = 8'h41; h_rd = 1; end
      OP_SWR: begin s_addr = 8'h10; s_wdata = wd; s_wr = 1; end
      OP_SRD: begin s_addr = 8'h10; s_rd = 1; end
      OP_SST: begin s_addr = 8'h11; s_rd = 1; end
      default: ;
    endcase
    #1;
    rd = (op == OP_HRD || op == OP_HST) ? h_rdata : s_rdata;
    edges(1);
    idle_bus();
    edges(3);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    do_reset();
    // R1 outputs after reset
    check("R1", {6'd0, s_drq_rx, s_drq_tx}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      int op;
      op = int'(VEC[i][23:16]);
      do_op(op, VEC[i][15:8], r);
      if (op == OP_HRD || op == OP_HST || op == OP_SRD || op == OP_SST)
        check($sformatf("R%0d step %0d", VEC[i][27:24], i), r, VEC[i][7:0]);
    end

    // R8 sticky until reset, R1 reset clears it
    do_reset();
    do_op(OP_HST, 8'h00, r); check("R1", r, 8'h00);
    do_op(OP_SST, 8'h00, r); check("R1", r, 8'h00);

    // R5 crossing latency, R6 DMA receive request
    h_addr = 8'h40; h_wdata = 8'h5A; h_wr = 1;
    edges(1); idle_bus();
    h_addr = 8'h41; h_rd = 1; #1;
    check("R5 writer full after 1 edge", h_rdata, 8'h01);
    check("R5 reader not yet after 1 edge", {7'd0, s_drq_rx}, 8'h00);
    edges(1); h_rd = 0; #1;
    check("R5 reader not yet after 2 edges", {7'd0, s_drq_rx}, 8'h00);
    edges(1); #1;
    check("R6 drq_rx after 3 edges", {7'd0, s_drq_rx}, 8'h01);
    s_dack_rx = 1; #1;
    check("R6 dack_rx data", s_rdata, 8'h5A);
    edges(1); s_dack_rx = 0; #1;
    check("R6 drq_rx drops", {7'd0, s_drq_rx}, 8'h00);
    edges(3);

    // R7 DMA transmit request
    #1; check("R7 no req when disabled", {7'd0, s_drq_tx}, 8'h00);
    s_tx_en = 1; #1;
    check("R7 req when enabled and empty", {7'd0, s_drq_tx}, 8'h01);
    s_wdata = 8'h9E; s_dack_tx = 1;
    edges(1); s_dack_tx = 0; #1;
    check("R7 req drops after dack", {7'd0, s_drq_tx}, 8'h00);
    edges(3);
    do_op(OP_HRD, 8'h00, r); check("R7 dma byte at host", r, 8'h9E);
    #1; check("R7 req back after host read", {7'd0, s_drq_tx}, 8'h01);
    s_tx_en = 0;

    // R4 foreign addresses are ignored
    h_addr = 8'h42; h_wdata = 8'hFF; h_wr = 1; h_rd = 0; #1;
    check("R4 foreign host addr reads zero", h_rdata, 8'h00);
    edges(1); idle_bus(); edges(3);
    do_op(OP_SST, 8'h00, r); check("R4 foreign write no effect", r, 8'h00);
    do_op(OP_HST, 8'h00, r); check("R4 foreign write no effect host", r, 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule